// File: doc/BRIEF.md
# ADC Sample Output Code Formatter

This block takes 14-bit converter samples, which always arrive in offset binary, and re-codes each one into the output coding in force. The codings are offset binary (passed through unchanged), two's complement and Gray code. The formatted sample leaves through a register, one clock after the input sample, with a valid flag delayed to match.

The block also resolves the physical output-driver mode: LVDS at low drive, LVDS at high drive, or single-ended CMOS. It exports only a 2-bit mode code for the pad logic. Both settings live in one 8-bit control register, written through a simple write-enable port. Each setting has a one-hot field in that register. When a field is zero, or holds anything other than a single set bit, the setting falls back to an already-decoded three-level strap pin.

The control register is cleared only by the hard reset. The soft reset flushes the output stage and leaves the register untouched.

Top module: `adc_code_formatter`

## Requirements
- R1: With control bits [2:0] = 3'b100, the output equals the input sample unchanged (offset binary).
- R2: With control bits [2:0] = 3'b001, the output is the input with its most significant bit inverted (two's complement).
- R3: With control bits [2:0] = 3'b010, the output is the Gray code g = b ^ (b >> 1) of the input b.
- R4: With control bits [2:0] = 3'b000, the coding follows `pinFmt`: 0 gives two's complement, 1 gives Gray code, 2 gives offset binary, and 3 also gives offset binary.
- R5: A format field that is nonzero but not one-hot (for example 3'b011, 3'b101 or 3'b111) behaves exactly like 3'b000, which means pin control.
- R6: `outMode` (0 = LVDS low drive, 1 = LVDS high drive, 2 = CMOS) comes from control bits [7:5] as follows.
  - 3'b001 gives 0, 3'b010 gives 1 and 3'b100 gives 2.
  - Any other value follows `pinMode` with the same codes, and `pinMode` 3 gives 2.
- R7: A sample with `smpValid` high appears on `fmtOut` with `fmtValid` high after exactly one rising edge. In a cycle without `smpValid`, `fmtValid` is low and `fmtOut` holds its last value.
- R8: `softRst` high at an edge clears `fmtValid` and `fmtOut` to zero, drops any sample offered at that edge, and leaves the control register unchanged.
- R9: While `rstN` is low, the control register, `fmtOut` and `fmtValid` are all zero.
- R10: A register write applies to samples offered from the cycle after the write edge. A sample offered in the same cycle as the write is coded with the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| softRst | input | 1 | Soft reset, synchronous, flushes the output stage only |
| cfgWe | input | 1 | Control register write strobe |
| cfgData | input | 8 | Control register write data; [7:5] mode field, [2:0] format field |
| pinFmt | input | 2 | Decoded three-level format strap |
| pinMode | input | 2 | Decoded three-level output-mode strap |
| smpIn | input | 14 | Input sample, offset binary |
| smpValid | input | 1 | Input sample qualifier |
| fmtOut | output | 14 | Formatted sample |
| fmtValid | output | 1 | Output sample qualifier |
| outMode | output | 2 | Resolved output-driver mode code |

## Verification
The assertions rely on three things about the inputs.
- The strobes `smpValid`, `cfgWe` and `softRst` are free of X.
- Any sample carried with `smpValid` is stable across the capturing edge.
- A write and a soft reset may coincide, because the write still lands.

The stimulus drives every input on the falling clock edge only. It holds `smpValid` low while `rstN` is low, and it offers each sample for exactly one cycle. The bench also places a write in the same cycle as a sample and a soft reset in the same cycle as a sample, so the ordering rules are exercised.

// File: rtl/code_fmt_pkg.sv
package code_fmt_pkg;

  typedef enum logic [1:0] {
    FMT_TWOS = 2'd0,
    FMT_GRAY = 2'd1,
    FMT_OFFS = 2'd2
  } fmtSel_e;

  typedef enum logic [1:0] {
    MODE_LVDS_LO = 2'd0,
    MODE_LVDS_HI = 2'd1,
    MODE_CMOS    = 2'd2
  } drvMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    flush;
    fmtSel_e fmt;
  } pathCtl_t;

  // Resolve a one-hot register field against a strap value.
  // Bit i of a one-hot field selects code i; anything else defers to the pin.
  // Pin values above 2 saturate to 2.
  function automatic logic [1:0] resolveSel(input logic [2:0] field, input logic [1:0] pin);
    logic [1:0] sel;
    sel = (pin > 2'd2) ? 2'd2 : pin;
    if ($onehot(field)) begin
      for (int i = 0; i < 3; i++) begin
        if (field[i]) sel = 2'(i);
      end
    end
    return sel;
  endfunction

endpackage

// File: rtl/code_fmt_ctrl.sv
module code_fmt_ctrl
  import code_fmt_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int FMT_LSB  = 0,
  parameter int MODE_LSB = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic [1:0]       pinFmt,
  input  logic [1:0]       pinMode,
  input  logic             smpValid,
  output pathCtl_t         pathCtl,
  output logic [1:0]       outMode
);

  localparam int FIELD_W = 3;

  logic [CFG_W-1:0]   cfgReg;
  logic [FIELD_W-1:0] fmtField;
  logic [FIELD_W-1:0] modeField;

  // Hard reset only; softRst deliberately absent
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (cfgWe) begin
      cfgReg <= cfgData;
    end
  end

  assign fmtField  = cfgReg[FMT_LSB +: FIELD_W];
  assign modeField = cfgReg[MODE_LSB +: FIELD_W];

  always_comb begin
    pathCtl.load  = smpValid;
    pathCtl.flush = softRst;
    pathCtl.fmt   = fmtSel_e'(resolveSel(fmtField, pinFmt));
  end

  assign outMode = resolveSel(modeField, pinMode);

  // R8
  soft_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && !cfgWe) |=> $stable(cfgReg));

  // R10
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (cfgReg == $past(cfgData)));

  // R6
  mode_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outMode != 2'd3);

endmodule

// File: rtl/code_fmt_path.sv
module code_fmt_path
  import code_fmt_pkg::*;
#(
  parameter int SMP_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathCtl_t         pathCtl,
  input  logic [SMP_W-1:0] smpIn,
  output logic [SMP_W-1:0] fmtOut,
  output logic             fmtValid
);

  localparam int MSB = SMP_W - 1;

  logic [SMP_W-1:0] coded;

  always_comb begin
    case (pathCtl.fmt)
      FMT_TWOS: coded = {~smpIn[MSB], smpIn[MSB-1:0]};
      FMT_GRAY: coded = smpIn ^ (smpIn >> 1);
      default:  coded = smpIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtOut   <= '0;
      fmtValid <= 1'b0;
    end else if (pathCtl.flush) begin
      fmtOut   <= '0;
      fmtValid <= 1'b0;
    end else begin
      fmtValid <= pathCtl.load;
      if (pathCtl.load) fmtOut <= coded;
    end
  end

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pathCtl.load && !pathCtl.flush) |=> fmtValid);

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pathCtl.load && !pathCtl.flush) |=> ($stable(fmtOut) && !fmtValid));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    pathCtl.flush |=> (!fmtValid && fmtOut == '0));

  // R1
  offs_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pathCtl.load && !pathCtl.flush && pathCtl.fmt == FMT_OFFS) |=> (fmtOut == $past(smpIn)));

  // R2
  twos_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pathCtl.load && !pathCtl.flush && pathCtl.fmt == FMT_TWOS) |=>
      (fmtOut[MSB] != $past(smpIn[MSB]) && fmtOut[MSB-1:0] == $past(smpIn[MSB-1:0])));

  // R3
  gray_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pathCtl.load && !pathCtl.flush && pathCtl.fmt == FMT_GRAY) |=> (fmtOut[MSB] == $past(smpIn[MSB])));

endmodule

// File: rtl/adc_code_formatter.sv
module adc_code_formatter
  import code_fmt_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic [1:0]       pinFmt,
  input  logic [1:0]       pinMode,
  input  logic [SMP_W-1:0] smpIn,
  input  logic             smpValid,
  output logic [SMP_W-1:0] fmtOut,
  output logic             fmtValid,
  output logic [1:0]       outMode
);

  pathCtl_t pathCtl;

  code_fmt_ctrl #(
    .CFG_W(CFG_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .softRst (softRst),
    .cfgWe   (cfgWe),
    .cfgData (cfgData),
    .pinFmt  (pinFmt),
    .pinMode (pinMode),
    .smpValid(smpValid),
    .pathCtl (pathCtl),
    .outMode (outMode)
  );

  code_fmt_path #(
    .SMP_W(SMP_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .pathCtl (pathCtl),
    .smpIn   (smpIn),
    .fmtOut  (fmtOut),
    .fmtValid(fmtValid)
  );

  // R9
  reset_clear_chk: assert property (@(posedge clk) !rstN |-> (!fmtValid && fmtOut == '0));

endmodule

// File: tb/adc_code_formatter_test.sv
`timescale 1ns/1ps
module adc_code_formatter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgData = '0;
  logic [1:0]  pinFmt = '0;
  logic [1:0]  pinMode = '0;
  logic [13:0] smpIn = '0;
  logic        smpValid = 1'b0;
  logic [13:0] fmtOut;
  logic        fmtValid;
  logic [1:0]  outMode;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  adc_code_formatter uut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .cfgWe(cfgWe), .cfgData(cfgData),
    .pinFmt(pinFmt), .pinMode(pinMode), .smpIn(smpIn), .smpValid(smpValid),
    .fmtOut(fmtOut), .fmtValid(fmtValid), .outMode(outMode)
  );

  // {cfg[7:0], pinFmt[1:0], sample[13:0], expected[13:0]}
  localparam int NVEC = 15;
  localparam logic [37:0] VEC [NVEC] = '{
    {8'h04, 2'd0, 14'h1234, 14'h1234},  // R1 offset binary
    {8'hE4, 2'd0, 14'h3FFF, 14'h3FFF},  // R1 mode bits ignored by format
    {8'h01, 2'd0, 14'h2000, 14'h0000},  // R2 mid-scale
    {8'h01, 2'd0, 14'h1FFF, 14'h3FFF},  // R2
    {8'h01, 2'd0, 14'h0000, 14'h2000},  // R2 zero
    {8'h02, 2'd0, 14'h3FFF, 14'h2000},  // R3 full scale
    {8'h02, 2'd0, 14'h0001, 14'h0001},  // R3
    {8'h02, 2'd0, 14'h2A5C, 14'h3F72},  // R3 mixed
    {8'h00, 2'd0, 14'h1234, 14'h3234},  // R4 pin two's complement
    {8'h00, 2'd1, 14'h0003, 14'h0002},  // R4 pin Gray
    {8'h00, 2'd2, 14'h0ABC, 14'h0ABC},  // R4 pin offset binary
    {8'h00, 2'd3, 14'h2001, 14'h2001},  // R4 pin value 3
    {8'h03, 2'd1, 14'h0002, 14'h0003},  // R5 011 -> pin Gray
    {8'h07, 2'd0, 14'h0005, 14'h2005},  // R5 111 -> pin two's
    {8'h05, 2'd2, 14'h1111, 14'h1111}   // R5 101 -> pin offset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgData = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // offer one sample at this negedge, return at the negedge after capture
  task automatic offer(input logic [13:0] s);
    smpValid = 1'b1; smpIn = s;
    @(negedge clk);
    smpValid = 1'b0;
  endtask

  initial begin
    pinMode = 2'd1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid in reset", 32'(fmtValid), 0);
    check("R9 data in reset", 32'(fmtOut), 0);
    check("R9 mode from pin with cleared register", 32'(outMode), 1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      writeCfg(VEC[i][37:30]);
      pinFmt = VEC[i][29:28];
      offer(VEC[i][27:14]);
      check($sformatf("R7 valid vec %0d", i), 32'(fmtValid), 1);
      check($sformatf("R1-5 table vec %0d", i), 32'(fmtOut), 32'(VEC[i][13:0]));
    end

    // R7 hold when idle
    @(negedge clk);
    check("R7 idle valid low", 32'(fmtValid), 0);
    check("R7 idle data held", 32'(fmtOut), 32'h1111);

    // R6 mode field
    pinMode = 2'd2;
    writeCfg(8'h20); check("R6 mode 001", 32'(outMode), 0);
    writeCfg(8'h40); check("R6 mode 010", 32'(outMode), 1);
    writeCfg(8'h80); check("R6 mode 100", 32'(outMode), 2);
    pinMode = 2'd0;
    writeCfg(8'h60); check("R6 mode 011 pin", 32'(outMode), 0);
    pinMode = 2'd3;
    writeCfg(8'h00); check("R6 mode 000 pin 3", 32'(outMode), 2);

    // R10 write and sample in the same cycle: old setting (offset binary) applies
    writeCfg(8'h04);
    cfgWe = 1'b1; cfgData = 8'h01; smpValid = 1'b1; smpIn = 14'h0000;
    @(negedge clk);
    cfgWe = 1'b0; smpValid = 1'b0;
    check("R10 same-cycle uses old format", 32'(fmtOut), 0);
    offer(14'h0000);
    check("R10 next sample uses new format", 32'(fmtOut), 32'h2000);

    // R8 soft reset flushes, register survives
    writeCfg(8'h81);
    offer(14'h0123);
    check("R8 pre-flush data", 32'(fmtOut), 32'h2123);
    softRst = 1'b1; smpValid = 1'b1; smpIn = 14'h0777;
    @(negedge clk);
    softRst = 1'b0; smpValid = 1'b0;
    check("R8 flush valid", 32'(fmtValid), 0);
    check("R8 flush data", 32'(fmtOut), 0);
    check("R8 mode kept", 32'(outMode), 2);
    pinFmt = 2'd2;
    offer(14'h0001);
    check("R8 format kept", 32'(fmtOut), 32'h2001);

    // R9 hard reset clears register
    rstN = 1'b0; pinMode = 2'd1;
    @(negedge clk);
    check("R9 hard reset valid", 32'(fmtValid), 0);
    check("R9 hard reset mode to pin", 32'(outMode), 1);
    rstN = 1'b1;
    @(negedge clk);
    offer(14'h0001);
    check("R9 format back to pin", 32'(fmtOut), 32'h0001);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule